// File: doc/BRIEF.md
# Jitter-Attenuating Elastic Bit Buffer

This block is a single-bit-wide elastic store for a serial data stream. Bits arrive with irregular timing: bursts, gaps and jitter are all allowed. Each arriving bit is marked by a one-cycle write enable in the fast reference domain of nominally 32.768 MHz. The buffer releases the bits again on a smoothed read strobe. The read strobe is normally issued once every 16 reference cycles, which gives 2.048 MHz.

The fill level can drift far from the middle of the buffer. When it does, the next read period is shortened to 15 cycles (the buffer is too full) or lengthened to 17 cycles (it is too empty). The read rate then pulls the fill back toward the centre.

The active depth is 32 or 128 bits, chosen by one mode input. A trip flag records every period that ran at 15 or 17. An error flag records every lost or repeated bit. A pass-through mode takes the buffer out of the data path entirely.

Top module: `ja_elastic_buf`

## Requirements
- R1: While reset is asserted, the block shows the following state:
  - the fill level is 16 (32-bit mode is assumed until the first clock after reset);
  - both flags are 0;
  - rd_bit is 0 and rd_stb is 0.
- R2: Outside pass-through, rd_stb is a single-cycle pulse. The gap between two pulses is the period length chosen at the earlier pulse. The first period after reset, a mode change or leaving pass-through is 16 cycles.
- R3: Bits leave in the order they were written. rd_bit changes on the clock edge that ends the rd_stb cycle. After any re-centring, the first half-depth bits read are 0. The fill level rises by one per accepted write and falls by one per read of a non-empty store.
- R4: If the fill level at a read strobe exceeds half depth plus the trip distance, the next period is 15 cycles and limit_trip is set. The trip distance is 60 in 128-bit mode and 14 in 32-bit mode.
- R5: If the fill level at a read strobe is below half depth minus the trip distance, the next period is 17 cycles and limit_trip is set.
- R6: limit_trip stays set until a status_clr pulse clears it. A clear in the same cycle as a new trip leaves it set.
- R7: A read strobe that finds the store empty repeats the previous output bit and sets xflow_err.
- R8: A write that finds the store full, with no read in the same cycle, overwrites the oldest bit. The fill level stays at the depth and xflow_err is set. xflow_err is cleared by status_clr, and a new error in the same cycle wins.
- R9: A change of deep_mode (0 = 32 bits, 1 = 128 bits) does the following in the next cycle:
  - re-centres the store to half of the new depth, with all contents 0;
  - clears both flags;
  - restarts the divider;
  - issues no strobe in the changing cycle.
- R10: While bypass is 1:
  - rd_bit equals wr_bit and rd_stb equals wr_en in the same cycle;
  - the store is held at half depth;
  - the trip flag cannot be set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, nominal 32.768 MHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One-cycle write enable for each incoming bit |
| wr_bit | input | 1 | Incoming data bit |
| deep_mode | input | 1 | Depth select: 0 for 32 bits, 1 for 128 bits |
| bypass | input | 1 | 1 routes input straight to output |
| status_clr | input | 1 | One-cycle clear of both sticky flags |
| rd_bit | output | 1 | Outgoing data bit |
| rd_stb | output | 1 | One-cycle read strobe |
| fill_lvl | output | 8 | Current number of stored bits |
| limit_trip | output | 1 | Sticky flag: a 15- or 17-cycle period occurred |
| xflow_err | output | 1 | Sticky flag: a bit was lost or repeated |

## Verification
The hardest case to reach is a clear that lands in the exact cycle the divider picks a shortened period. This needs the store to be pinned full while a strobe is imminent. The stimulus writes on every cycle until the store saturates and overwrites. It then watches rd_stb at drive time and raises status_clr only in a strobe cycle. Reaching the 17-cycle period in 128-bit mode also needs a long silent drain from full. That drain carries the store through the lower threshold and on into repeated underflow.

// File: rtl/ja_pkg.sv
package ja_pkg;

  typedef enum logic [1:0] {
    RATE_NOM  = 2'd0,
    RATE_FAST = 2'd1,
    RATE_SLOW = 2'd2
  } rate_e;

  // Length of one read period for a given rate choice.
  function automatic int unsigned period_of(input rate_e r, input int unsigned nom);
    case (r)
      RATE_FAST: return nom - 1;
      RATE_SLOW: return nom + 1;
      default:   return nom;
    endcase
  endfunction

endpackage

// File: rtl/ja_bit_store.sv
module ja_bit_store #(
  parameter int DEPTH_MAX = 128,
  parameter int RST_HALF  = 16,
  parameter int AW        = $clog2(DEPTH_MAX)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic [AW:0]   depth_lvl,
  input  logic          wr_en,
  input  logic          wr_bit,
  input  logic          rd_adv,
  output logic          rd_bit
);

  logic [DEPTH_MAX-1:0] bits_q, bits_n;
  logic [AW-1:0]        wp_q, wp_n, rp_q, rp_n;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p, input logic [AW:0] d);
    if ({1'b0, p} == d - 1'b1) return '0;
    return p + 1'b1;
  endfunction

  always_comb begin
    bits_n = bits_q;
    wp_n   = wp_q;
    rp_n   = rp_q;
    if (restart) begin
      bits_n = '0;
      wp_n   = depth_lvl[AW:1];
      rp_n   = '0;
    end else begin
      if (wr_en) begin
        bits_n[wp_q] = wr_bit;
        wp_n         = bump(wp_q, depth_lvl);
      end
      if (rd_adv) begin
        rp_n = bump(rp_q, depth_lvl);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_q <= '0;
      wp_q   <= AW'(RST_HALF);
      rp_q   <= '0;
    end else begin
      bits_q <= bits_n;
      wp_q   <= wp_n;
      rp_q   <= rp_n;
    end
  end

  assign rd_bit = bits_q[rp_q];

endmodule

// File: rtl/ja_occupancy.sv
module ja_occupancy #(
  parameter int FW       = 8,
  parameter int RST_FILL = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic [FW-1:0] depth_lvl,
  input  logic          wr_req,
  input  logic          rd_req,
  output logic [FW-1:0] fill,
  output logic          rd_take,
  output logic          wr_drop,
  output logic          under,
  output logic          over
);

  logic [FW-1:0] fill_q, fill_n;

  always_comb begin
    rd_take = rd_req && (fill_q != '0);
    under   = rd_req && (fill_q == '0);
    over    = wr_req && !rd_take && (fill_q == depth_lvl);
    wr_drop = over;
    if (restart) begin
      fill_n = depth_lvl >> 1;
    end else if (over) begin
      fill_n = fill_q;
    end else begin
      fill_n = fill_q + FW'(wr_req) - FW'(rd_take);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fill_q <= FW'(RST_FILL);
    else        fill_q <= fill_n;
  end

  assign fill = fill_q;

endmodule

// File: rtl/ja_rate_gen.sv
module ja_rate_gen
  import ja_pkg::*;
#(
  parameter int NOM_DIV = 16,
  parameter int CW      = $clog2(NOM_DIV + 2)
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  restart,
  input  rate_e next_rate,
  output logic  tick
);

  logic [CW-1:0] div_q, div_n, len_q, len_n;

  always_comb begin
    tick  = !restart && (div_q == len_q - 1'b1);
    div_n = div_q + 1'b1;
    len_n = len_q;
    if (restart) begin
      div_n = '0;
      len_n = CW'(NOM_DIV);
    end else if (tick) begin
      div_n = '0;
      len_n = CW'(period_of(next_rate, NOM_DIV));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      len_q <= CW'(NOM_DIV);
    end else begin
      div_q <= div_n;
      len_q <= len_n;
    end
  end

endmodule

// File: rtl/ja_elastic_buf.sv
module ja_elastic_buf
  import ja_pkg::*;
#(
  parameter int DEPTH_MAX    = 128,
  parameter int DEPTH_MIN    = 32,
  parameter int TRIP_DEEP    = 60,
  parameter int TRIP_SHALLOW = 14,
  parameter int NOM_DIV      = 16,
  parameter int FW           = $clog2(DEPTH_MAX) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_bit,
  input  logic          deep_mode,
  input  logic          bypass,
  input  logic          status_clr,
  output logic          rd_bit,
  output logic          rd_stb,
  output logic [FW-1:0] fill_lvl,
  output logic          limit_trip,
  output logic          xflow_err
);

  localparam int AW = FW - 1;

  logic          deep_q;
  logic          mode_chg, restart;
  logic [FW-1:0] depth_c, half_c, trip_c, hi_c, lo_c;
  logic [FW-1:0] fill_c;
  rate_e         rate_c;
  logic          tick, wr_req;
  logic          rd_take, wr_drop, under, over;
  logic          store_bit;
  logic          rd_q, rd_n, trip_q, trip_n, err_q, err_n;

  assign mode_chg = (deep_mode != deep_q);
  assign restart  = mode_chg || bypass;
  assign wr_req   = wr_en && !restart;

  always_comb begin
    depth_c = deep_mode ? FW'(DEPTH_MAX) : FW'(DEPTH_MIN);
    trip_c  = deep_mode ? FW'(TRIP_DEEP) : FW'(TRIP_SHALLOW);
    half_c  = depth_c >> 1;
    hi_c    = half_c + trip_c;
    lo_c    = half_c - trip_c;
    if (fill_c > hi_c)      rate_c = RATE_FAST;
    else if (fill_c < lo_c) rate_c = RATE_SLOW;
    else                    rate_c = RATE_NOM;
  end

  ja_rate_gen #(.NOM_DIV(NOM_DIV)) u_rate (
    .clk(clk), .rst_n(rst_n), .restart(restart),
    .next_rate(rate_c), .tick(tick)
  );

  ja_occupancy #(.FW(FW), .RST_FILL(DEPTH_MIN / 2)) u_occ (
    .clk(clk), .rst_n(rst_n), .restart(restart), .depth_lvl(depth_c),
    .wr_req(wr_req), .rd_req(tick), .fill(fill_c),
    .rd_take(rd_take), .wr_drop(wr_drop), .under(under), .over(over)
  );

  ja_bit_store #(.DEPTH_MAX(DEPTH_MAX), .RST_HALF(DEPTH_MIN / 2), .AW(AW)) u_store (
    .clk(clk), .rst_n(rst_n), .restart(restart), .depth_lvl(depth_c),
    .wr_en(wr_req), .wr_bit(wr_bit), .rd_adv(rd_take || wr_drop),
    .rd_bit(store_bit)
  );

  always_comb begin
    rd_n = rd_q;
    if (rd_take) rd_n = store_bit;

    trip_n = trip_q;
    if (mode_chg)                      trip_n = 1'b0;
    else if (tick && rate_c != RATE_NOM) trip_n = 1'b1;
    else if (status_clr)               trip_n = 1'b0;

    err_n = err_q;
    if (mode_chg)          err_n = 1'b0;
    else if (under || over) err_n = 1'b1;
    else if (status_clr)   err_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      deep_q <= 1'b0;
      rd_q   <= 1'b0;
      trip_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      deep_q <= deep_mode;
      rd_q   <= rd_n;
      trip_q <= trip_n;
      err_q  <= err_n;
    end
  end

  assign rd_bit     = bypass ? wr_bit : rd_q;
  assign rd_stb     = bypass ? wr_en  : tick;
  assign fill_lvl   = fill_c;
  assign limit_trip = trip_q;
  assign xflow_err  = err_q;

endmodule

// File: rtl/ja_elastic_buf_chk.sv
module ja_elastic_buf_chk #(
  parameter int DEPTH_MAX    = 128,
  parameter int DEPTH_MIN    = 32,
  parameter int TRIP_DEEP    = 60,
  parameter int TRIP_SHALLOW = 14,
  parameter int FW           = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          bypass,
  input logic          status_clr,
  input logic          rd_stb,
  input logic [FW-1:0] fill_lvl,
  input logic          limit_trip,
  input logic          xflow_err,
  input logic          mode_chg,
  input logic          deep_q
);

  logic [FW:0] c_dep, c_half, c_hi, c_lo, c_fill;

  always_comb begin
    c_dep  = deep_q ? (FW+1)'(DEPTH_MAX) : (FW+1)'(DEPTH_MIN);
    c_half = c_dep >> 1;
    c_hi   = c_half + (deep_q ? (FW+1)'(TRIP_DEEP) : (FW+1)'(TRIP_SHALLOW));
    c_lo   = c_half - (deep_q ? (FW+1)'(TRIP_DEEP) : (FW+1)'(TRIP_SHALLOW));
    c_fill = {1'b0, fill_lvl};
  end

  assert_stb_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !bypass) |=> (bypass || !rd_stb));

  assert_fast_trip_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !bypass && !mode_chg && c_fill > c_hi) |=> limit_trip);

  assert_slow_trip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !bypass && !mode_chg && c_fill < c_lo) |=> limit_trip);

  assert_trip_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (limit_trip && !status_clr && !mode_chg) |=> limit_trip);

  assert_underflow_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !bypass && !mode_chg && c_fill == '0) |=> xflow_err);

  assert_overflow_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !bypass && !mode_chg && !rd_stb && c_fill == c_dep) |=> xflow_err);

  assert_fill_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    c_fill <= c_dep);

  assert_recentre_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> (c_fill == c_half && !limit_trip && !xflow_err));

  assert_bypass_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |=> (c_fill == c_half));

endmodule

bind ja_elastic_buf ja_elastic_buf_chk #(
  .DEPTH_MAX(DEPTH_MAX), .DEPTH_MIN(DEPTH_MIN),
  .TRIP_DEEP(TRIP_DEEP), .TRIP_SHALLOW(TRIP_SHALLOW), .FW(FW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .bypass(bypass),
  .status_clr(status_clr), .rd_stb(rd_stb), .fill_lvl(fill_lvl),
  .limit_trip(limit_trip), .xflow_err(xflow_err),
  .mode_chg(mode_chg), .deep_q(deep_q)
);

// File: tb/ja_elastic_buf_bench.sv
module ja_elastic_buf_bench;

  localparam int DMAX = 128, DMIN = 32, TD = 60, TS = 14, NOM = 16, FW = 8;

  logic clk = 1'b0;
  logic rst_n, wr_en, wr_bit, deep_mode, bypass, status_clr;
  logic rd_bit, rd_stb, limit_trip, xflow_err;
  logic [FW-1:0] fill_lvl;

  ja_elastic_buf u_ja_elastic_buf (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bit(wr_bit),
    .deep_mode(deep_mode), .bypass(bypass), .status_clr(status_clr),
    .rd_bit(rd_bit), .rd_stb(rd_stb), .fill_lvl(fill_lvl),
    .limit_trip(limit_trip), .xflow_err(xflow_err)
  );

  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Scoreboard state: expected store contents and control model.
  bit q[$];
  bit m_last, m_deep, m_trip, m_err, pend, exp_bit, mon_on, last_ok;
  int m_cnt, m_len, cyc, last_stb, seen15, seen17;
  int dep, half, trp, fill;
  bit mchg, stb, st, se;

  function automatic void recentre(input bit deep);
    q.delete();
    for (int i = 0; i < (deep ? DMAX : DMIN) / 2; i++) q.push_back(1'b0);
  endfunction

  always @(negedge clk) begin
    if (mon_on) begin
      cyc++;
      if (pend && !bypass)
        chk(rd_bit == exp_bit, "R3 data order", int'(rd_bit), int'(exp_bit));
      pend = 0;
      chk(int'(fill_lvl) == q.size(), "R3 fill level", int'(fill_lvl), q.size());
      chk(limit_trip == m_trip, "R6 trip flag", int'(limit_trip), int'(m_trip));
      chk(xflow_err == m_err, "R7 R8 error flag", int'(xflow_err), int'(m_err));
      mchg = (deep_mode != m_deep);
      st = 0;
      se = 0;
      if (bypass) begin
        chk(rd_bit == wr_bit, "R10 bypass data", int'(rd_bit), int'(wr_bit));
        chk(rd_stb == wr_en, "R10 bypass strobe", int'(rd_stb), int'(wr_en));
      end
      if (mchg || bypass) begin
        if (!bypass) chk(rd_stb == 1'b0, "R9 no strobe on change", int'(rd_stb), 0);
        recentre(deep_mode);
        m_cnt = 0;
        m_len = NOM;
        last_ok = 0;
      end else begin
        dep  = m_deep ? DMAX : DMIN;
        half = dep / 2;
        trp  = m_deep ? TD : TS;
        fill = q.size();
        stb  = (m_cnt == m_len - 1);
        chk(rd_stb == stb, "R2 strobe timing", int'(rd_stb), int'(stb));
        if (rd_stb) begin
          if (last_ok && cyc - last_stb == NOM - 1) seen15++;
          if (last_ok && cyc - last_stb == NOM + 1) seen17++;
          last_stb = cyc;
          last_ok  = 1;
        end
        if (stb) begin
          if (fill > half + trp)      m_len = NOM - 1;
          else if (fill < half - trp) m_len = NOM + 1;
          else                        m_len = NOM;
          st = (m_len != NOM);
          m_cnt = 0;
          if (fill == 0) begin
            exp_bit = m_last;
            se = 1;
          end else begin
            exp_bit = q.pop_front();
            m_last = exp_bit;
          end
          pend = 1;
        end else begin
          m_cnt++;
        end
        if (wr_en) begin
          if (q.size() == dep) begin
            void'(q.pop_front());
            se = 1;
          end
          q.push_back(wr_bit);
        end
      end
      m_deep = deep_mode;
      if (mchg) begin
        m_trip = 0;
        m_err  = 0;
      end else begin
        if (st) m_trip = 1;
        else if (status_clr) m_trip = 0;
        if (se) m_err = 1;
        else if (status_clr) m_err = 0;
      end
    end
  end

  task automatic step(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic steady(input int n);
    for (int i = 0; i < n; i++) begin
      wr_en  = 1'b1;
      wr_bit = 1'($urandom);
      step(1);
      wr_en = 1'b0;
      step(NOM - 1);
    end
  endtask

  task automatic burst(input int n);
    for (int i = 0; i < n; i++) begin
      wr_en  = 1'b1;
      wr_bit = 1'($urandom);
      step(1);
    end
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(4 * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_bit = 1'b0; deep_mode = 1'b0;
    bypass = 1'b0; status_clr = 1'b0;
    mon_on = 0; pend = 0; last_ok = 0; seen15 = 0; seen17 = 0; cyc = 0;
    step(3);
    chk(fill_lvl == 8'd16, "R1 reset fill", int'(fill_lvl), 16);
    chk(!limit_trip, "R1 reset trip", int'(limit_trip), 0);
    chk(!xflow_err, "R1 reset error", int'(xflow_err), 0);
    chk(!rd_bit, "R1 reset data", int'(rd_bit), 0);
    chk(!rd_stb, "R1 reset strobe", int'(rd_stb), 0);
    recentre(1'b0);
    m_deep = 0; m_last = 0; m_cnt = 0; m_len = NOM; m_trip = 0; m_err = 0;
    mon_on = 1;
    rst_n  = 1'b1;

    // R2 R3: nominal rate, balanced traffic
    steady(24);

    // R4 R8: saturate the shallow store
    burst(40);
    chk(limit_trip, "R4 fast trip seen", int'(limit_trip), 1);
    chk(xflow_err, "R8 overflow seen", int'(xflow_err), 1);
    chk(fill_lvl == 8'd32, "R8 full stays at depth", int'(fill_lvl), 32);

    // R6: clear in a quiet cycle, then clear against a new trip
    wr_en = 1'b1;
    while (rd_stb) step(1);
    status_clr = 1'b1;
    step(1);
    status_clr = 1'b0;
    chk(!limit_trip, "R6 clear works", int'(limit_trip), 0);
    while (!rd_stb) begin
      wr_bit = 1'($urandom);
      step(1);
    end
    status_clr = 1'b1;
    step(1);
    status_clr = 1'b0;
    chk(limit_trip, "R6 set beats clear", int'(limit_trip), 1);

    // R5 R7: drain past empty
    wr_en = 1'b0;
    step(900);
    chk(seen15 > 0, "R4 period 15 observed", seen15, 1);
    chk(seen17 > 0, "R5 period 17 observed", seen17, 1);
    chk(xflow_err, "R7 underflow seen", int'(xflow_err), 1);
    chk(fill_lvl == 8'd0, "R7 empty", int'(fill_lvl), 0);

    // R9: switch to deep mode
    deep_mode = 1'b1;
    step(1);
    chk(fill_lvl == 8'd64, "R9 deep recentre", int'(fill_lvl), 64);
    chk(!limit_trip && !xflow_err, "R9 flags cleared", int'(limit_trip | xflow_err), 0);
    steady(10);
    seen15 = 0;
    seen17 = 0;
    burst(100);
    chk(limit_trip, "R4 deep fast trip", int'(limit_trip), 1);
    wr_en = 1'b0;
    step(2400);
    chk(seen15 > 0, "R4 deep period 15", seen15, 1);
    chk(seen17 > 0, "R5 deep period 17", seen17, 1);

    // R10: pass-through
    bypass = 1'b1;
    for (int i = 0; i < 40; i++) begin
      wr_en  = 1'($urandom);
      wr_bit = 1'($urandom);
      step(1);
    end
    wr_en = 1'b0;
    chk(fill_lvl == 8'd64, "R10 store held", int'(fill_lvl), 64);
    bypass = 1'b0;
    steady(8);

    // R9: back to shallow mode
    deep_mode = 1'b0;
    step(1);
    chk(fill_lvl == 8'd16, "R9 shallow recentre", int'(fill_lvl), 16);
    steady(8);
    step(20);
    finish_run();
  end

endmodule